// File: doc/BRIEF.md
# System Power Request Controller

This peripheral sits on a 32-bit APB-style register bus and gives software a way to ask the platform for system-level actions. It has two registers. A read-only capability word reports that power control is available. A write-only command word turns a written code into a one-cycle request pulse on one of three outputs: system reset, orderly halt, or panic shutdown. The circuits that act on these pulses lie outside the block.

The block decodes a 256-byte window. Any access that does not hit an implemented register returns zero or has no effect, and it raises a one-cycle strobe so that the access can be logged. The block also has an interrupt output that is held low. It keeps an interrupt-enable word that is cleared at reset, but nothing writes to that word.

Top module: `pwr_req_ctrl`

## Requirements
- R1: A read of byte offset 0x00 returns 0x00000001 during its access cycle. Bit 0 set means power control is supported.
- R2: A write of exactly 0x00000001 to byte offset 0x04 sets `reset_req` high for exactly the one cycle that follows the access cycle.
- R3: A write of exactly 0x00000002 to offset 0x04 sets `halt_req` high for exactly the one cycle that follows the access cycle.
- R4: A write of exactly 0x00000003 to offset 0x04 sets `panic_req` high for exactly the one cycle that follows the access cycle.
- R5: A write to offset 0x04 of 0, or of any value above 3 (the whole 32-bit word is compared), raises no request and no unimplemented strobe.
- R6: A read of any offset other than 0x00, including the write-only offset 0x04 and unaligned offsets, returns zero. It also sets `unimp_access` high for the one cycle that follows the access.
- R7: A write to any offset other than 0x04 raises no request. It sets `unimp_access` high for the one cycle that follows the access.
- R8: While `rst_n` is low, all request outputs, `unimp_access` and `irq` are low.
- R9: `irq` stays low at all times.
- R10: At most one of the three request outputs is high in any cycle. A request never lasts into a second cycle.
- R11: Every transfer completes in its first access cycle, with `pready` high and `pslverr` low, including transfers that miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte offset within the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access cycle |
| pready | output | 1 | Transfer ready, always 1 |
| pslverr | output | 1 | Error response, always 0 |
| reset_req | output | 1 | One-cycle system reset request |
| halt_req | output | 1 | One-cycle orderly halt request |
| panic_req | output | 1 | One-cycle panic shutdown request |
| unimp_access | output | 1 | One-cycle strobe for an access to an unimplemented register |
| irq | output | 1 | Interrupt, held low |

## Verification
The request pulse from a command write comes out in the cycle after the access. That cycle is the same one in which the next transfer may already be in its setup phase. So a pulse can overlap the start of a following access, which may itself be a miss or a feature read. The bench sweeps every offset with a set of data words, alternating between transfers issued back to back and transfers separated by an idle cycle. For each transfer it checks the read data in the access cycle, then the pulse and the strobe one cycle later, and in the idle case that everything has returned low. This confirms that the overlapping transfer neither stretches nor hides the earlier pulse.

// File: rtl/pwr_req_pkg.sv
package pwr_req_pkg;

  localparam int unsigned CAPS_OFS = 0;
  localparam int unsigned CMD_OFS  = 4;

  // Capability word: bit 0 = power control present
  localparam logic [31:0] CAPS_WORD = 32'h0000_0001;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_RESET = 2'd1,
    OP_HALT  = 2'd2,
    OP_PANIC = 2'd3
  } op_e;

  typedef struct packed {
    logic rst;
    logic halt;
    logic panic;
  } req_t;

endpackage

// File: rtl/pwr_req_decode.sv
module pwr_req_decode
  import pwr_req_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  output logic          caps_rd,
  output logic          cmd_wr,
  output logic          miss
);

  logic access;
  logic caps_hit;
  logic cmd_hit;

  always_comb begin
    access   = psel & penable;
    caps_hit = (paddr == AW'(CAPS_OFS));
    cmd_hit  = (paddr == AW'(CMD_OFS));
    caps_rd  = access & ~pwrite & caps_hit;
    cmd_wr   = access &  pwrite & cmd_hit;
    miss     = access & (pwrite ? ~cmd_hit : ~caps_hit);
  end

endmodule

// File: rtl/pwr_req_cmd.sv
module pwr_req_cmd
  import pwr_req_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  logic [DW-1:0] wdata,
  output req_t          req_q
);

  localparam int unsigned OPW = 2;

  logic  code_ok;
  op_e   op;
  req_t  req_d;

  always_comb begin
    code_ok = (wdata[DW-1:OPW] == '0);
    op      = op_e'(wdata[OPW-1:0]);
    req_d   = '0;
    if (cmd_wr && code_ok) begin
      unique case (op)
        OP_RESET: req_d.rst   = 1'b1;
        OP_HALT:  req_d.halt  = 1'b1;
        OP_PANIC: req_d.panic = 1'b1;
        default:  req_d       = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= req_d;
  end

  // R10: the request outputs are mutually exclusive
  a_r10_one_req: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_q));

  // R5: a word outside the code range raises nothing
  a_r5_bad_code_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !code_ok) |=> (req_q == '0));

endmodule

// File: rtl/pwr_req_rdmux.sv
module pwr_req_rdmux
  import pwr_req_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          caps_rd,
  output logic [DW-1:0] rdata
);

  localparam logic [DW-1:0] CAPS = DW'(CAPS_WORD);

  for (genvar b = 0; b < DW; b++) begin : g_bit
    assign rdata[b] = caps_rd & CAPS[b];
  end

endmodule

// File: rtl/pwr_req_ctrl.sv
module pwr_req_ctrl
  import pwr_req_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [DW-1:0] pwdata,
  output logic [DW-1:0] prdata,
  output logic          pready,
  output logic          pslverr,
  output logic          reset_req,
  output logic          halt_req,
  output logic          panic_req,
  output logic          unimp_access,
  output logic          irq
);

  localparam logic [DW-1:0] IRQ_SOURCES = '0;

  logic          caps_rd;
  logic          cmd_wr;
  logic          miss;
  req_t          req_q;
  logic          unimp_d, unimp_q;
  logic [DW-1:0] irq_en_d, irq_en_q;

  pwr_req_decode #(.AW(AW)) u_dec (
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .caps_rd (caps_rd),
    .cmd_wr  (cmd_wr),
    .miss    (miss)
  );

  pwr_req_cmd #(.DW(DW)) u_cmd (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd_wr (cmd_wr),
    .wdata  (pwdata),
    .req_q  (req_q)
  );

  pwr_req_rdmux #(.DW(DW)) u_rd (
    .caps_rd (caps_rd),
    .rdata   (prdata)
  );

  always_comb begin
    unimp_d  = miss;
    irq_en_d = irq_en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unimp_q  <= 1'b0;
      irq_en_q <= '0;
    end else begin
      unimp_q  <= unimp_d;
      irq_en_q <= irq_en_d;
    end
  end

  assign pready       = 1'b1;
  assign pslverr      = 1'b0;
  assign reset_req    = req_q.rst;
  assign halt_req     = req_q.halt;
  assign panic_req    = req_q.panic;
  assign unimp_access = unimp_q;
  assign irq          = |(irq_en_q & IRQ_SOURCES);

  // R2: a reset request follows a write of code 1 to the command offset
  a_r2_reset_cause: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> $past(psel && penable && pwrite &&
                        paddr == AW'(CMD_OFS) && pwdata == DW'(1)));

  // R3: a halt request follows a write of code 2
  a_r3_halt_cause: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> $past(psel && penable && pwrite &&
                       paddr == AW'(CMD_OFS) && pwdata == DW'(2)));

  // R4: a panic request follows a write of code 3
  a_r4_panic_cause: assert property (@(posedge clk) disable iff (!rst_n)
    panic_req |-> $past(psel && penable && pwrite &&
                        paddr == AW'(CMD_OFS) && pwdata == DW'(3)));

  // R6/R7: the strobe follows only an access that missed
  a_r6_unimp_cause: assert property (@(posedge clk) disable iff (!rst_n)
    unimp_access |-> $past(psel && penable &&
                           (pwrite ? paddr != AW'(CMD_OFS)
                                   : paddr != AW'(CAPS_OFS))));

  // R7: a missed access never coincides with a request
  a_r7_miss_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    unimp_access |-> !(reset_req || halt_req || panic_req));

endmodule

// File: tb/pwr_req_ctrl_test.sv
module pwr_req_ctrl_test;

  logic        clk;
  logic        rst_n;
  logic        psel, penable, pwrite;
  logic [7:0]  paddr;
  logic [31:0] pwdata;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic        reset_req, halt_req, panic_req, unimp_access, irq;

  int errs   = 0;
  int checks = 0;
  bit done   = 0;

  pwr_req_ctrl uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .psel         (psel),
    .penable      (penable),
    .pwrite       (pwrite),
    .paddr        (paddr),
    .pwdata       (pwdata),
    .prdata       (prdata),
    .pready       (pready),
    .pslverr      (pslverr),
    .reset_req    (reset_req),
    .halt_req     (halt_req),
    .panic_req    (panic_req),
    .unimp_access (unimp_access),
    .irq          (irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called just after a negedge; returns just after the negedge that follows the access.
  task automatic xfer(input logic wr, input logic [7:0] a, input logic [31:0] d,
                      output logic [31:0] rd, output logic rdy, output logic err,
                      output logic [3:0] flags, output logic irqv);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    #1;
    rd = prdata; rdy = pready; err = pslverr;
    @(negedge clk);
    #1;
    flags = {reset_req, halt_req, panic_req, unimp_access};
    irqv  = irq;
    psel = 1'b0; penable = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] vals [8];
    logic [31:0] rd;
    logic        rdy, err, irqv;
    logic [3:0]  fl, ef;
    string       tag;
    int          n;

    vals[0] = 32'h0;        vals[1] = 32'h1;        vals[2] = 32'h2;
    vals[3] = 32'h3;        vals[4] = 32'h4;        vals[5] = 32'h101;
    vals[6] = 32'h8000_0001; vals[7] = 32'hFFFF_FFFF;

    rst_n = 1'b0; psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    paddr = '0; pwdata = '0;
    repeat (3) @(negedge clk);
    // R8: outputs quiet in reset
    chk("R8 requests in reset", {28'd0, reset_req, halt_req, panic_req, unimp_access}, 32'd0);
    chk("R8 irq in reset", {31'd0, irq}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;

    n = 0;
    for (int wr = 0; wr < 2; wr++) begin
      for (int a = 0; a < 256; a++) begin
        for (int k = 0; k < (wr ? 8 : 1); k++) begin
          logic [31:0] d;
          d = wr ? vals[k] : 32'hA5A5_5A5A;
          xfer(wr[0], 8'(a), d, rd, rdy, err, fl, irqv);
          ef[3] = wr[0] && a == 4 && d == 32'd1;
          ef[2] = wr[0] && a == 4 && d == 32'd2;
          ef[1] = wr[0] && a == 4 && d == 32'd3;
          ef[0] = wr[0] ? (a != 4) : (a != 0);
          if (!wr[0])      tag = (a == 0) ? "R1" : "R6";
          else if (a != 4) tag = "R7";
          else if (d == 1) tag = "R2";
          else if (d == 2) tag = "R3";
          else if (d == 3) tag = "R4";
          else             tag = "R5";
          if (!wr[0]) chk({tag, " read data"}, rd, (a == 0) ? 32'h1 : 32'h0);
          chk({tag, " request/strobe pulses"}, {28'd0, fl}, {28'd0, ef});
          chk("R11 ready/err", {30'd0, rdy, err}, 32'd2);
          chk("R9 irq low", {31'd0, irqv}, 32'd0);
          chk("R10 one request", ($countones(fl[3:1]) <= 1) ? 32'd1 : 32'd0, 32'd1);
          n++;
          if (n % 2 == 0) begin
            @(negedge clk);
            #1;
            chk("R10 pulse lasts one cycle",
                {28'd0, reset_req, halt_req, panic_req, unimp_access}, 32'd0);
          end
        end
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule